// File: doc/BRIEF.md
# Four-Channel Prescaled Down-Counter Timer

This block holds four independent down-counters behind a small word-addressed register bus that completes every access in one cycle. Each channel counts down at the system clock divided by 1, 16 or 256. It can be switched on or off, made 16 or 32 bits wide, and set to handle reaching zero in one of three ways: reload a stored value, wrap to all ones, or stop there for good.

Every channel owns four registers: a load register, a read-only count, a control byte and a deferred-reload register. A write to the load register sets both the count and the reload value at once. A write to the deferred-reload register changes only the reload value, so it takes effect at the next wrap. A shared bank of four registers gathers the channels' zero events into sticky status bits, each with its own enable. The single interrupt output is the OR of the enabled status bits.

Top module: `quad_timer`

## Requirements
- R1: After the active-low reset, every register reads 0, no channel runs and `irq` is low.
- R2: Registers are 32-bit words, selected with `addr[1:0]` equal to 0. The shared bank holds the interrupt enable mask at 0x00, the sticky status at 0x04, the enabled status (status AND mask) at 0x08 and the write-1-to-clear register at 0x0C. Channel n (0..3) starts at 0x10 + 0x10·n and holds, in order, the load register (+0x0), the current count (+0x4), the control byte (+0x8) and the deferred-reload register (+0xC). The load and deferred-reload registers both read back the current reload value. Control bits 5:4 read as 0.
- R3: A write to a channel's load register sets its count and its reload value at the next clock edge, whatever the counter was doing. It also restarts that channel's prescaler.
- R4: Control bit 7 = 1 runs the channel, and the count drops by one per prescaler tick. With bit 7 = 0 the count holds.
- R5: Control bits 3:2 set the tick rate: 00 gives a tick every clock, 01 every 16 clocks and 10 or 11 every 256 clocks. A channel's first tick comes that many clocks after its load write.
- R6: A tick that takes the count from 1 to 0 sets status bit n in the same clock edge.
- R7: A tick at count 0 reloads the reload value when control bit 6 = 1. With bit 6 = 0 it wraps to the all-ones value of the current width. Neither case sets status.
- R8: With control bit 0 = 1 (single shot), a channel whose count is 0 stays at 0 and raises no further events.
- R9: A write to the deferred-reload register leaves the count unchanged and supplies the value reloaded at the next wrap.
- R10: Control bit 1 = 1 makes the counter 32 bits wide. With bit 1 = 0 it is 16 bits: values written to the load and deferred-reload registers lose bits 31:16, and the count reads with bits 31:16 at 0.
- R11: Writing a 1 to bit n of the clear register clears status bit n. A zero event in the same cycle wins over the clear. A mask write replaces the whole mask. `irq` is high exactly when some status bit and its mask bit are both 1.
- R12: Writes to the status, enabled-status and count registers, and to unmapped or misaligned addresses, change nothing. Reads of the clear register and of unmapped or misaligned addresses return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; every register and counter updates on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe; `wdata` is written to `addr` on this edge |
| addr | input | 8 | Byte address of the register being read or written |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, valid in the same cycle |
| irq | output | 1 | Combined interrupt: OR of status AND mask |

## Verification
The hardest situations to reach from the ports are the coincidences: a deferred-reload write, a load write, a control write or a clear landing on the exact edge where a channel wraps or reaches zero, and a 32-to-16-bit width change while the count holds a large value. Directed sequences pin down each mode and each prescale rate with hand-counted cycle numbers. A long seeded random phase then uses short load values and mostly undivided clocks, so these collisions happen thousands of times. Every read and every cycle's `irq` is compared with a cycle-level model written from the requirements.

// File: rtl/qt_pkg.sv
// Package qt_pkg
// Shared types and constants of the four-channel timer: the control byte
// layout, register slot numbers and helpers for the width mask and the
// prescaler limit. Assumes 32-bit counters with a 16-bit narrow mode.
package qt_pkg;

    localparam int CNT_W = 32;
    localparam int PRE_W = 8;

    // Register slot inside a 16-byte group (address bits 3:2)
    localparam logic [1:0] SLOT_LOAD  = 2'd0;
    localparam logic [1:0] SLOT_COUNT = 2'd1;
    localparam logic [1:0] SLOT_CTRL  = 2'd2;
    localparam logic [1:0] SLOT_DEFER = 2'd3;

    localparam logic [1:0] SLOT_MASK  = 2'd0;
    localparam logic [1:0] SLOT_RAW   = 2'd1;
    localparam logic [1:0] SLOT_MSKD  = 2'd2;
    localparam logic [1:0] SLOT_CLR   = 2'd3;

    // Control byte fields (bit positions are part of the programming model)
    typedef struct packed {
        logic       run;       // bit 7
        logic       reload;    // bit 6: 1 = reload at zero, 0 = wrap to all ones
        logic [1:0] rate;      // bits 3:2
        logic       wide;      // bit 1
        logic       single;    // bit 0
    } ctrl_t;

    function automatic ctrl_t ctrl_from_word(input logic [CNT_W-1:0] w);
        ctrl_t c;
        c.run    = w[7];
        c.reload = w[6];
        c.rate   = w[3:2];
        c.wide   = w[1];
        c.single = w[0];
        return c;
    endfunction

    function automatic logic [CNT_W-1:0] ctrl_to_word(input ctrl_t c);
        return {{(CNT_W-8){1'b0}}, c.run, c.reload, 2'b00, c.rate, c.wide, c.single};
    endfunction

    function automatic logic [CNT_W-1:0] width_mask(input logic wide);
        return wide ? {CNT_W{1'b1}} : {{(CNT_W-16){1'b0}}, {16{1'b1}}};
    endfunction

    function automatic logic [PRE_W-1:0] rate_limit(input logic [1:0] rate);
        logic [PRE_W-1:0] lim;
        case (rate)
            2'b00:   lim = PRE_W'(0);
            2'b01:   lim = PRE_W'(15);
            default: lim = PRE_W'(255);
        endcase
        return lim;
    endfunction

endpackage

// File: rtl/qt_prescaler.sv
// Module qt_prescaler
// Divides the clock for one channel: emits a one-cycle tick every 1, 16
// or 256 clocks while running. Restart clears the phase so that the
// first tick follows a load by the full period. Assumes PRE_W >= 8.
module qt_prescaler
    import qt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       restart,
    input  logic [1:0] rate,
    output logic       tick
);

    logic [PRE_W-1:0] phase_q;
    logic [PRE_W-1:0] limit;

    // Period limit for the selected rate
    always_comb limit = rate_limit(rate);

    // Tick when the phase reaches the limit, never in a restart cycle
    always_comb tick = run && !restart && (phase_q == limit);

    // Phase counter: cleared when stopped, restarted or on a tick
    always_ff @(posedge clk) begin
        if (!rst_n)                        phase_q <= '0;
        else if (!run || restart || tick)  phase_q <= '0;
        else                               phase_q <= phase_q + 1'b1;
    end

endmodule

// File: rtl/qt_channel.sv
// Module qt_channel
// One down-counter with its control byte and reload value. A load write
// sets count and reload; a deferred write sets only reload. At zero the
// channel reloads, wraps to all ones or parks, per its control byte.
// Assumes at most one of ld_wr, defer_wr and ctrl_wr per cycle.
module qt_channel
    import qt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_wr,
    input  logic             defer_wr,
    input  logic             ctrl_wr,
    input  logic [CNT_W-1:0] wdata,
    output ctrl_t            ctrl_q,
    output logic [CNT_W-1:0] count_q,
    output logic [CNT_W-1:0] reload_q,
    output logic             zero_evt
);

    logic             tick;
    logic [CNT_W-1:0] wmask;
    logic [CNT_W-1:0] count_d;
    logic [CNT_W-1:0] reload_d;
    logic [CNT_W-1:0] dec;

    qt_prescaler u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (ctrl_q.run),
        .restart (ld_wr),
        .rate    (ctrl_q.rate),
        .tick    (tick)
    );

    // Mask for the active width and the decremented count
    always_comb begin
        wmask = width_mask(ctrl_q.wide);
        dec   = (count_q - 1'b1) & wmask;
    end

    // Next count, next reload value and the reaching-zero event
    always_comb begin
        count_d  = count_q & wmask;
        reload_d = reload_q;
        zero_evt = 1'b0;
        if (ld_wr) begin
            count_d  = wdata & wmask;
            reload_d = wdata & wmask;
        end else begin
            if (defer_wr) reload_d = wdata & wmask;
            if (tick) begin
                if (count_q == '0) begin
                    if (!ctrl_q.single)
                        count_d = ctrl_q.reload ? (reload_q & wmask) : wmask;
                end else begin
                    count_d  = dec;
                    zero_evt = (dec == '0);
                end
            end
        end
    end

    // Counter and reload registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q  <= '0;
            reload_q <= '0;
        end else begin
            count_q  <= count_d;
            reload_q <= reload_d;
        end
    end

    // Control byte register
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (ctrl_wr) ctrl_q <= ctrl_from_word(wdata);
    end

endmodule

// File: rtl/qt_irq.sv
// Module qt_irq
// Shared interrupt bank: sticky status bits set by channel zero events,
// a replace-on-write enable mask and write-1-to-clear. A same-cycle event
// wins over a clear. The output is the OR of status AND mask.
module qt_irq #(
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] evt,
    input  logic              mask_wr,
    input  logic              clr_wr,
    input  logic [NUM_CH-1:0] wbits,
    output logic [NUM_CH-1:0] mask_q,
    output logic [NUM_CH-1:0] raw_q,
    output logic [NUM_CH-1:0] masked,
    output logic              irq
);

    logic [NUM_CH-1:0] clr_bits;

    // Bits requested for clearing this cycle
    always_comb clr_bits = clr_wr ? wbits : '0;

    // Sticky status: events set, clear requests drop
    always_ff @(posedge clk) begin
        if (!rst_n) raw_q <= '0;
        else        raw_q <= (raw_q & ~clr_bits) | evt;
    end

    // Enable mask, replaced whole on a write
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (mask_wr) mask_q <= wbits;
    end

    // Enabled status and the combined interrupt
    always_comb begin
        masked = raw_q & mask_q;
        irq    = |masked;
    end

endmodule

// File: rtl/quad_timer.sv
// Module quad_timer
// Top of the four-channel timer: decodes the single-cycle register bus,
// instantiates one qt_channel per channel and the shared qt_irq bank, and
// muxes read data. Reads are combinational; writes take effect at the edge.
// Assumes ADDR_W leaves room for NUM_CH+1 groups of 16 bytes.
module quad_timer
    import qt_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wdata,
    output logic [CNT_W-1:0]  rdata,
    output logic              irq
);

    localparam int GRP_W = ADDR_W - 4;

    logic                          aligned;
    logic [GRP_W-1:0]              grp;
    logic [1:0]                    slot;
    logic                          hit_shared;
    logic [NUM_CH-1:0]             hit_ch;
    logic [NUM_CH-1:0]             ld_wr;
    logic [NUM_CH-1:0]             defer_wr;
    logic [NUM_CH-1:0]             ctrl_wr;
    logic [NUM_CH-1:0]             evt;
    logic [NUM_CH-1:0]             run_v;
    logic [NUM_CH-1:0]             single_v;
    logic [NUM_CH-1:0]             wide_v;
    logic [NUM_CH-1:0][CNT_W-1:0]  count_all;
    logic [NUM_CH-1:0][CNT_W-1:0]  reload_all;
    ctrl_t                         ctrl_all [NUM_CH];
    logic [NUM_CH-1:0]             mask_q;
    logic [NUM_CH-1:0]             raw_q;
    logic [NUM_CH-1:0]             masked;
    logic                          mask_wr;
    logic                          clr_wr;

    // Address split into group, slot and alignment
    always_comb begin
        aligned    = (addr[1:0] == 2'b00);
        grp        = addr[ADDR_W-1:4];
        slot       = addr[3:2];
        hit_shared = aligned && (grp == '0);
        mask_wr    = wr_en && hit_shared && (slot == SLOT_MASK);
        clr_wr     = wr_en && hit_shared && (slot == SLOT_CLR);
    end

    generate
        for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
            // Per-channel group hit and write strobes
            always_comb begin
                hit_ch[i]   = aligned && (grp == GRP_W'(i + 1));
                ld_wr[i]    = wr_en && hit_ch[i] && (slot == SLOT_LOAD);
                defer_wr[i] = wr_en && hit_ch[i] && (slot == SLOT_DEFER);
                ctrl_wr[i]  = wr_en && hit_ch[i] && (slot == SLOT_CTRL);
            end

            qt_channel u_chan (
                .clk      (clk),
                .rst_n    (rst_n),
                .ld_wr    (ld_wr[i]),
                .defer_wr (defer_wr[i]),
                .ctrl_wr  (ctrl_wr[i]),
                .wdata    (wdata),
                .ctrl_q   (ctrl_all[i]),
                .count_q  (count_all[i]),
                .reload_q (reload_all[i]),
                .zero_evt (evt[i])
            );

            // Control fields brought out flat for observation
            always_comb begin
                run_v[i]    = ctrl_all[i].run;
                single_v[i] = ctrl_all[i].single;
                wide_v[i]   = ctrl_all[i].wide;
            end
        end
    endgenerate

    qt_irq #(.NUM_CH(NUM_CH)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt     (evt),
        .mask_wr (mask_wr),
        .clr_wr  (clr_wr),
        .wbits   (wdata[NUM_CH-1:0]),
        .mask_q  (mask_q),
        .raw_q   (raw_q),
        .masked  (masked),
        .irq     (irq)
    );

    // Read data mux; unmapped, misaligned and clear-register reads give 0
    always_comb begin
        rdata = '0;
        if (hit_shared) begin
            case (slot)
                SLOT_MASK: rdata = CNT_W'(mask_q);
                SLOT_RAW:  rdata = CNT_W'(raw_q);
                SLOT_MSKD: rdata = CNT_W'(masked);
                default:   rdata = '0;
            endcase
        end
        for (int i = 0; i < NUM_CH; i++) begin
            if (hit_ch[i]) begin
                case (slot)
                    SLOT_COUNT: rdata = count_all[i];
                    SLOT_CTRL:  rdata = ctrl_to_word(ctrl_all[i]);
                    default:    rdata = reload_all[i];
                endcase
            end
        end
    end

endmodule

// File: rtl/qt_checker.sv
// Module qt_checker
// Assertion checker bound to quad_timer. Watches the counts, control
// fields, write strobes and the interrupt bank across clock edges.
module qt_checker #(
    parameter int NUM_CH = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   irq,
    input  logic [NUM_CH-1:0]      mask_q,
    input  logic [NUM_CH-1:0]      raw_q,
    input  logic                   clr_wr,
    input  logic [NUM_CH-1:0]      wbits,
    input  logic [NUM_CH-1:0]      run_v,
    input  logic [NUM_CH-1:0]      single_v,
    input  logic [NUM_CH-1:0]      wide_v,
    input  logic [NUM_CH-1:0]      ld_wr,
    input  logic [NUM_CH-1:0][31:0] count_all
);

    AST_MASK_GATES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> !irq); // R11

    generate
        for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
            AST_HOLD_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
                (!run_v[i] && !ld_wr[i] && (wide_v[i] || count_all[i][31:16] == 16'h0))
                |=> $stable(count_all[i])); // R4

            AST_SINGLE_PARKS: assert property (@(posedge clk) disable iff (!rst_n)
                (run_v[i] && single_v[i] && count_all[i] == 32'h0 && !ld_wr[i])
                |=> (count_all[i] == 32'h0)); // R8

            AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
                !wide_v[i] |=> (count_all[i][31:16] == 16'h0)); // R10

            AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
                (raw_q[i] && !(clr_wr && wbits[i])) |=> raw_q[i]); // R11
        end
    endgenerate

endmodule

bind quad_timer qt_checker #(.NUM_CH(NUM_CH)) u_qt_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq       (irq),
    .mask_q    (mask_q),
    .raw_q     (raw_q),
    .clr_wr    (clr_wr),
    .wbits     (wdata[NUM_CH-1:0]),
    .run_v     (run_v),
    .single_v  (single_v),
    .wide_v    (wide_v),
    .ld_wr     (ld_wr),
    .count_all (count_all)
);

// File: tb/tb_quad_timer.sv
module tb_quad_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = 8'h0;
    logic [31:0] wdata = 32'h0;
    logic [31:0] rdata;
    logic        irq;

    int checks = 0;
    int errs = 0;
    bit done = 0;
    bit irq_watch = 0;

    quad_timer dut (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .addr  (addr),
        .wdata (wdata),
        .rdata (rdata),
        .irq   (irq)
    );

    always #10 clk = ~clk;

    // Cycle-level reference state built from the requirements
    logic [31:0] m_cnt [4];
    logic [31:0] m_rel [4];
    logic [7:0]  m_ctl [4];
    int          m_pre [4];
    logic [3:0]  m_mask;
    logic [3:0]  m_raw;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) begin
                m_cnt[i] = 0; m_rel[i] = 0; m_ctl[i] = 0; m_pre[i] = 0;
            end
            m_mask = 0; m_raw = 0;
        end else begin
            logic [3:0] ev;
            ev = 0;
            for (int i = 0; i < 4; i++) begin
                logic [31:0] wm;
                int lim;
                bit ld, bg, ct, tk;
                wm  = m_ctl[i][1] ? 32'hFFFF_FFFF : 32'h0000_FFFF;
                lim = (m_ctl[i][3:2] == 2'b00) ? 0 : (m_ctl[i][3:2] == 2'b01) ? 15 : 255;
                ld  = wr_en && (addr == 8'(8'h10 + 16*i));
                ct  = wr_en && (addr == 8'(8'h18 + 16*i));
                bg  = wr_en && (addr == 8'(8'h1C + 16*i));
                tk  = 0;
                if (ld) begin
                    m_cnt[i] = wdata & wm;
                    m_rel[i] = wdata & wm;
                    m_pre[i] = 0;
                end else begin
                    if (m_ctl[i][7]) begin
                        if (m_pre[i] == lim) begin tk = 1; m_pre[i] = 0; end
                        else m_pre[i] = m_pre[i] + 1;
                    end else m_pre[i] = 0;
                    if (tk && m_cnt[i] == 0) begin
                        if (!m_ctl[i][0]) m_cnt[i] = m_ctl[i][6] ? (m_rel[i] & wm) : wm;
                    end else if (tk) begin
                        m_cnt[i] = (m_cnt[i] - 1) & wm;
                        if (m_cnt[i] == 0) ev[i] = 1;
                    end else begin
                        m_cnt[i] = m_cnt[i] & wm;
                    end
                    if (bg) m_rel[i] = wdata & wm;
                end
                if (ct) m_ctl[i] = wdata[7:0] & 8'hCF;
            end
            m_raw = (m_raw & ~((wr_en && addr == 8'h0C) ? wdata[3:0] : 4'h0)) | ev;
            if (wr_en && addr == 8'h00) m_mask = wdata[3:0];
        end
    end

    function automatic logic [31:0] exp_rd(input logic [7:0] a);
        int g;
        if (a[1:0] != 2'b00) return 0;
        g = int'(a[7:4]);
        if (g == 0) begin
            case (a[3:2])
                2'd0: return 32'(m_mask);
                2'd1: return 32'(m_raw);
                2'd2: return 32'(m_raw & m_mask);
                default: return 0;
            endcase
        end
        if (g > 4) return 0;
        case (a[3:2])
            2'd1: return m_cnt[g-1];
            2'd2: return 32'(m_ctl[g-1]);
            default: return m_rel[g-1];
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Compare a read against the model
    task automatic rd(input logic [7:0] a, input string tag);
        addr = a; wr_en = 1'b0; #1;
        check(tag, rdata, exp_rd(a));
    endtask

    // Compare a read against a hand-computed value (and the model)
    task automatic rdl(input logic [7:0] a, input logic [31:0] e, input string tag);
        addr = a; wr_en = 1'b0; #1;
        check(tag, rdata, e);
        check(tag, rdata, exp_rd(a));
    endtask

    // Combined interrupt against the model every cycle
    always @(negedge clk) begin
        if (irq_watch) check("R11 irq", 32'(irq), 32'(|(m_raw & m_mask)));
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    endtask

    initial begin
        #(20 * 200000);
        errs++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'd2024));
        idle(3);
        rst_n = 1'b1;
        idle(1);
        irq_watch = 1;

        // R1: reset state of every register
        for (int a = 0; a < 8'h50; a += 4) rdl(8'(a), 32'h0, "R1 reset read");
        check("R1 irq after reset", 32'(irq), 32'h0);

        // R2, R10: control byte layout and narrow load masking
        wr(8'h38, 32'hFF);
        rdl(8'h38, 32'hCF, "R2 control readback");
        wr(8'h38, 32'h0);
        wr(8'h10, 32'hABCD_1234);
        rdl(8'h10, 32'h0000_1234, "R10 narrow load");
        rdl(8'h14, 32'h0000_1234, "R3 count set by load");
        rdl(8'h1C, 32'h0000_1234, "R2 deferred reads reload");
        wr(8'h28, 32'h02);
        wr(8'h20, 32'hABCD_1234);
        rdl(8'h24, 32'hABCD_1234, "R10 wide load");

        // R12: ignored writes and zero reads
        wr(8'h14, 32'h55);
        rdl(8'h14, 32'h0000_1234, "R12 count write ignored");
        wr(8'h04, 32'hF);
        rdl(8'h04, 32'h0, "R12 status write ignored");
        wr(8'h11, 32'h77);
        rdl(8'h10, 32'h0000_1234, "R12 misaligned write ignored");
        rdl(8'h0C, 32'h0, "R12 clear reads zero");
        rdl(8'h50, 32'h0, "R12 unmapped read");
        rdl(8'h12, 32'h0, "R12 misaligned read");

        // R5, R6: divide by 16, load 3 reaches zero on the 48th edge
        wr(8'h00, 32'hF);
        wr(8'h28, 32'hC6);
        wr(8'h20, 32'd3);
        idle(47);
        rdl(8'h04, 32'h0, "R5 no event before 48 clocks");
        rdl(8'h24, 32'd1, "R5 count after 47 clocks");
        idle(1);
        rdl(8'h04, 32'h2, "R6 event at zero");
        check("R11 irq with mask", 32'(irq), 32'h1);
        wr(8'h28, 32'h00);

        // R11: clear and mask behaviour
        wr(8'h0C, 32'h2);
        rdl(8'h04, 32'h0, "R11 clear drops status");
        wr(8'h00, 32'h0);
        wr(8'h18, 32'h81);
        wr(8'h10, 32'd2);
        idle(2);
        rdl(8'h04, 32'h1, "R6 single-shot event");
        rdl(8'h08, 32'h0, "R11 masked status gated");
        check("R11 irq masked off", 32'(irq), 32'h0);
        wr(8'h00, 32'h1);
        rdl(8'h08, 32'h1, "R11 masked status");

        // R8: single shot parks at zero with no more events
        wr(8'h0C, 32'h1);
        idle(20);
        rdl(8'h14, 32'h0, "R8 parked at zero");
        rdl(8'h04, 32'h0, "R8 no repeat event");

        // R7: narrow wrap to all ones, then periodic reload
        wr(8'h48, 32'h80);
        wr(8'h40, 32'd1);
        idle(2);
        rdl(8'h44, 32'h0000_FFFF, "R7 wrap to all ones");
        wr(8'h48, 32'hC0);
        wr(8'h40, 32'd2);
        idle(3);
        rdl(8'h44, 32'd2, "R7 periodic reload");

        // R9: deferred reload applies at next wrap only
        wr(8'h48, 32'h40);
        wr(8'h40, 32'd2);
        wr(8'h4C, 32'd9);
        rdl(8'h44, 32'd2, "R9 count unchanged");
        rdl(8'h40, 32'd9, "R9 reload replaced");
        wr(8'h48, 32'hC0);
        idle(3);
        rdl(8'h44, 32'd9, "R9 reload at wrap");

        // R4: stopped channel holds its count
        wr(8'h48, 32'h40);
        rd(8'h44, "R4 count at stop");
        idle(5);
        rd(8'h44, "R4 count held");

        // R5: code 11 divides by 256
        wr(8'h38, 32'hCE);
        wr(8'h30, 32'd1);
        idle(255);
        rdl(8'h34, 32'd1, "R5 rate 11 before tick");
        idle(1);
        rdl(8'h34, 32'd0, "R5 rate 11 tick");
        wr(8'h38, 32'h0);

        // Seeded random phase against the model
        for (int n = 0; n < 8000; n++) begin
            int r;
            r = int'($urandom % 10);
            if (r < 5) begin
                idle(1);
            end else if (r < 8) begin
                int pick;
                logic [7:0] a;
                logic [31:0] d;
                pick = int'($urandom % 12);
                a = 8'(8'h10 + 16 * ($urandom % 4) + 4 * ($urandom % 4));
                d = ($urandom % 4 == 0) ? $urandom : ($urandom % 40);
                if (pick == 0) a = 8'h00;
                if (pick == 1) begin a = 8'h0C; d = $urandom; end
                if (a[3:2] == 2'd2)
                    d = {24'h0, ($urandom % 5 != 0), 1'($urandom), 2'b00,
                         ($urandom % 8 == 0) ? 2'($urandom) : 2'b00,
                         1'($urandom), 1'($urandom % 3 == 0)};
                wr(a, d);
            end else begin
                logic [7:0] a;
                a = 8'(($urandom % 21) * 4);
                if (a[3:2] == 2'd1) rd(a, "R4 random count read");
                else if (a[7:4] == 0) rd(a, "R11 random status read");
                else rd(a, "R2 random register read");
                idle(1);
            end
        end

        finish_run();
    end

endmodule